// File: doc/BRIEF.md
# Serial-Shared GPIO Port Controller

This block runs an 8-bit general-purpose I/O port whose pins also serve two asynchronous serial channels and one SPI interface. Software programs a direction register, an output latch and a small control register over a plain byte-wide register bus. The registers are written on a clock edge and read combinationally. For every pin the block works out three pad controls: output enable, output value and pullup enable. It does this by merging the direction bits with overrides from the serial and SPI peripherals.

The pins are mapped as follows. Pins 0 and 1 are receive and transmit of serial channel 0. Pins 2 and 3 are receive and transmit of serial channel 1. Pins 4, 5, 6 and 7 carry SPI data-in, data-out, clock and select. Each override has its own rule. Serial pins are forced to a fixed direction unless loop mode is on. SPI pins that act as inputs are always forced to inputs. SPI pins that act as outputs drive SPI data only when their direction bit is set. Pad inputs pass through a two-flop synchronizer. From there they are routed to the peripherals and to the port data read.

All ports are plain control and status signals. There is no streaming interface, so no valid/ready back-pressure rules apply.

Top module: `sgp_port`

## Requirements
- R1: With no override active, a direction bit of 1 makes its pin an output driving the output-latch bit. A direction bit of 0 makes the pin an input with output enable low.
- R2: After reset, the direction register and output latch read 0x00 and the control register reads 0x08. No pin is output-enabled and every pin has its pullup enabled.
- R3: While `loop_mode` is 0, pins 0 and 2 are inputs and pins 1 and 3 are outputs driving `sci0_tx` and `sci1_tx`, whatever their direction bits hold.
- R4: While `loop_mode` is 1, pins 0 to 3 behave as plain GPIO per R1.
- R5: While `spi_en` is 1, the SPI input pins are forced to inputs. In master mode (`spi_master`=1) that is pin 4. In slave mode it is pins 5, 6 and 7.
- R6: While `spi_en` is 1, an SPI output pin with its direction bit set drives `spi_out[i-4]`. With its direction bit clear it stays an undriven input, readable as GPIO.
- R7: `pin_pu[i]` is 1 exactly when control bit 3 (pullup enable) is 1 and pin i is not output-enabled.
- R8: In the control register, bits 3, 2 and 0 are writable and read back. Bits 7..4 and bit 1 always read 0.
- R9: A write with `reg_wr`=1 updates the addressed register at the next rising clock edge. The address map is 0 = port data/output latch, 1 = direction, 2 = control. Reads are combinational. Address 3 reads 0x00 and writes to it change nothing.
- R10: A read of address 0 returns, per bit, the output-latch bit for an output-enabled pin and the synchronized pad level otherwise.
- R11: A pad change on `pin_in` appears on the synchronized values (port read, `sci0_rx`=pin 0, `sci1_rx`=pin 2, `spi_in`=pins 7..4) after the second rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| loop_mode | input | 1 | Serial loop-mode control; 0 forces serial pin directions |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI master mode select |
| sci0_tx | input | 1 | Serial channel 0 transmit data |
| sci1_tx | input | 1 | Serial channel 1 transmit data |
| spi_out | input | 4 | SPI drive values for pins 7..4 |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pullup enables |
| sci0_rx | output | 1 | Synchronized pin 0 level |
| sci1_rx | output | 1 | Synchronized pin 2 level |
| spi_in | output | 4 | Synchronized levels of pins 7..4 |

## Verification
A corrupted direction or control bit shows on `pin_oe` or `pin_pu` in the same cycle as the corrupting edge, because the pad controls are combinational from register state. It is also visible on the next register read. A synchronizer stage that is missing or stuck shows as a pad change arriving one cycle early or never. For that reason the bench samples the port read after both the first and the second edge. Override errors appear only under particular `loop_mode`, `spi_en` and `spi_master` combinations, so each combination is driven with direction patterns that disagree with the forced result.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int PORT_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int SPI_N   = 4;
  localparam int SYNC_N  = 2;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  localparam logic [PORT_W-1:0] CTRL_MASK  = 8'h0D;
  localparam logic [PORT_W-1:0] CTRL_RESET = 8'h08;
  localparam int CTRL_PU_BIT = 3;

  localparam int PIN_RX0 = 0;
  localparam int PIN_TX0 = 1;
  localparam int PIN_RX1 = 2;
  localparam int PIN_TX1 = 3;
  localparam int PIN_SPI0 = 4;

  typedef enum logic [1:0] {ROLE_GPIO, ROLE_SER_RX, ROLE_SER_TX, ROLE_SPI} pin_role_e;

  function automatic pin_role_e role_of(input int idx);
    if (idx == PIN_RX0 || idx == PIN_RX1) return ROLE_SER_RX;
    if (idx == PIN_TX0 || idx == PIN_TX1) return ROLE_SER_TX;
    if (idx >= PIN_SPI0 && idx < PIN_SPI0 + SPI_N) return ROLE_SPI;
    return ROLE_GPIO;
  endfunction
endpackage

// File: rtl/sgp_sync.sv
module sgp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sgp_regs.sv
module sgp_regs
  import sgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] port_view,
  output logic [PORT_W-1:0] rdata,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] latch_q,
  output logic              pu_en
);
  logic [PORT_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
      ctrl_q  <= CTRL_RESET;
    end else if (wr) begin
      unique case (addr)
        A_DATA:  latch_q <= wdata;
        A_DIR:   dir_q   <= wdata;
        A_CTRL:  ctrl_q  <= wdata & CTRL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      A_DATA:  rdata = port_view;
      A_DIR:   rdata = dir_q;
      A_CTRL:  rdata = ctrl_q;
      default: rdata = '0;
    endcase
  end

  assign pu_en = ctrl_q[CTRL_PU_BIT];
endmodule

// File: rtl/sgp_pinmux.sv
module sgp_pinmux
  import sgp_pkg::*;
(
  input  logic              loop_mode,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic              sci0_tx,
  input  logic              sci1_tx,
  input  logic [SPI_N-1:0]  spi_out,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] latch_q,
  input  logic              pu_en,
  output logic [PORT_W-1:0] oe,
  output logic [PORT_W-1:0] dout,
  output logic [PORT_W-1:0] pu
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    localparam pin_role_e ROLE = role_of(i);
    if (ROLE == ROLE_SER_RX) begin : g_rx
      assign oe[i]   = loop_mode & dir_q[i];
      assign dout[i] = latch_q[i];
    end else if (ROLE == ROLE_SER_TX) begin : g_tx
      logic tx_val;
      assign tx_val  = (i == PIN_TX0) ? sci0_tx : sci1_tx;
      assign oe[i]   = loop_mode ? dir_q[i] : 1'b1;
      assign dout[i] = loop_mode ? latch_q[i] : tx_val;
    end else if (ROLE == ROLE_SPI) begin : g_spi
      localparam int J = i - PIN_SPI0;
      logic spi_drives;
      logic spi_input;
      assign spi_drives = (J == 0) ? ~spi_master : spi_master;
      assign spi_input  = spi_en & ~spi_drives;
      assign oe[i]      = ~spi_input & dir_q[i];
      assign dout[i]    = (spi_en & spi_drives & dir_q[i]) ? spi_out[J] : latch_q[i];
    end else begin : g_gpio
      assign oe[i]   = dir_q[i];
      assign dout[i] = latch_q[i];
    end
    assign pu[i] = pu_en & ~oe[i];
  end
endmodule

// File: rtl/sgp_port.sv
module sgp_port
  import sgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  input  logic              loop_mode,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic              sci0_tx,
  input  logic              sci1_tx,
  input  logic [SPI_N-1:0]  spi_out,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_pu,
  output logic              sci0_rx,
  output logic              sci1_rx,
  output logic [SPI_N-1:0]  spi_in
);
  logic [PORT_W-1:0] pad_sync;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] port_view;
  logic              pu_en;

  sgp_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_sync)
  );

  assign port_view = (pin_oe & latch_q) | (~pin_oe & pad_sync);

  sgp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .port_view(port_view), .rdata(reg_rdata), .dir_q(dir_q), .latch_q(latch_q),
    .pu_en(pu_en)
  );

  sgp_pinmux u_mux (
    .loop_mode(loop_mode), .spi_en(spi_en), .spi_master(spi_master),
    .sci0_tx(sci0_tx), .sci1_tx(sci1_tx), .spi_out(spi_out),
    .dir_q(dir_q), .latch_q(latch_q), .pu_en(pu_en),
    .oe(pin_oe), .dout(pin_out), .pu(pin_pu)
  );

  assign sci0_rx = pad_sync[PIN_RX0];
  assign sci1_rx = pad_sync[PIN_RX1];
  assign spi_in  = pad_sync[PIN_SPI0 +: SPI_N];
endmodule

// File: rtl/sgp_port_chk.sv
module sgp_port_chk
  import sgp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [PORT_W-1:0] reg_wdata,
  input logic              loop_mode,
  input logic              spi_en,
  input logic              spi_master,
  input logic              sci0_tx,
  input logic              sci1_tx,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] pin_pu,
  input logic [PORT_W-1:0] dir_q
);
  AST_RX_FORCED_IN: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_mode |-> (!pin_oe[PIN_RX0] && !pin_oe[PIN_RX1])); // R3
  AST_TX_FORCED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_mode |-> (pin_oe[PIN_TX0] && pin_oe[PIN_TX1] &&
                    pin_out[PIN_TX0] == sci0_tx && pin_out[PIN_TX1] == sci1_tx)); // R3
  AST_LOOP_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && !spi_en) |-> (pin_oe == dir_q)); // R4
  AST_SPI_MASTER_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> !pin_oe[PIN_SPI0]); // R5
  AST_SPI_SLAVE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> (pin_oe[7:5] == 3'b000)); // R5
  AST_SPI_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> (pin_oe[7:5] == dir_q[7:5])); // R6
  AST_PU_NOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu & pin_oe) == '0)); // R7
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DIR) |=> (dir_q == $past(reg_wdata))); // R9
endmodule

bind sgp_port sgp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .loop_mode(loop_mode), .spi_en(spi_en),
  .spi_master(spi_master), .sci0_tx(sci0_tx), .sci1_tx(sci1_tx),
  .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .dir_q(dir_q)
);

// File: tb/sgp_port_test.sv
module sgp_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       loop_mode = 1'b1;
  logic       spi_en = 1'b0;
  logic       spi_master = 1'b1;
  logic       sci0_tx = 1'b0;
  logic       sci1_tx = 1'b0;
  logic [3:0] spi_out = 4'h0;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe, pin_pu;
  logic       sci0_rx, sci1_rx;
  logic [3:0] spi_in;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sgp_port uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .loop_mode(loop_mode),
    .spi_en(spi_en), .spi_master(spi_master), .sci0_tx(sci0_tx), .sci1_tx(sci1_tx),
    .spi_out(spi_out), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pu(pin_pu), .sci0_rx(sci0_rx), .sci1_rx(sci1_rx), .spi_in(spi_in)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    reg_read(2'd1, v); check("R2 dir after reset", v, 8'h00);
    reg_read(2'd2, v); check("R2 ctrl after reset", v, 8'h08);
    reg_read(2'd0, v); check("R2 port read after reset", v, 8'h00);
    check("R2 oe after reset", pin_oe, 8'h00);
    check("R2 pullups after reset", pin_pu, 8'hFF);
  endtask

  task automatic t_gpio;
    logic [7:0] v;
    loop_mode = 1'b1; spi_en = 1'b0;
    reg_write(2'd0, 8'hA5);
    reg_write(2'd1, 8'hF0);
    #1;
    check("R1 oe follows dir", pin_oe, 8'hF0);
    check("R1 out from latch", pin_out & pin_oe, 8'hA0);
    check("R4 loop gpio oe", pin_oe & 8'h0F, 8'h00);
    reg_write(2'd1, 8'h0F);
    #1 check("R4 loop gpio serial pins out", pin_oe, 8'h0F);
    check("R7 pullups on inputs", pin_pu, 8'hF0);
    reg_read(2'd1, v); check("R9 dir readback", v, 8'h0F);
  endtask

  task automatic t_serial;
    loop_mode = 1'b0; sci0_tx = 1'b1; sci1_tx = 1'b0;
    reg_write(2'd1, 8'h05);
    #1;
    check("R3 serial oe forced", pin_oe & 8'h0F, 8'h0A);
    check("R3 tx values", pin_out & 8'h0A, 8'h02);
    sci0_tx = 1'b0; sci1_tx = 1'b1;
    #1 check("R3 tx values swapped", pin_out & 8'h0A, 8'h08);
    check("R7 pullups vs forced oe", pin_pu & 8'h0F, 8'h05);
    loop_mode = 1'b1;
    #1 check("R4 back to gpio", pin_oe & 8'h0F, 8'h05);
  endtask

  task automatic t_spi;
    loop_mode = 1'b1; spi_en = 1'b1; spi_master = 1'b1; spi_out = 4'b1010;
    reg_write(2'd0, 8'h00);
    reg_write(2'd1, 8'hB0);
    #1;
    check("R5 master data-in forced input", pin_oe & 8'hF0, 8'hA0);
    check("R6 master drives spi values", pin_out & 8'hA0, 8'hA0);
    spi_master = 1'b0;
    #1 check("R5 slave inputs forced", pin_oe & 8'hF0, 8'h10);
    check("R6 slave data-in drives", pin_out & 8'h10, 8'h00);
    spi_out = 4'b0001;
    #1 check("R6 slave data-in value", pin_out & 8'h10, 8'h10);
    reg_write(2'd1, 8'h00);
    #1 check("R6 dir clear means no drive", pin_oe & 8'hF0, 8'h00);
    spi_en = 1'b0; spi_master = 1'b1;
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    reg_write(2'd2, 8'hFF);
    reg_read(2'd2, v); check("R8 ctrl masks", v, 8'h0D);
    reg_write(2'd2, 8'h05);
    reg_read(2'd2, v); check("R8 ctrl clear pullup", v, 8'h05);
    check("R7 pullups disabled", pin_pu, 8'h00);
    reg_write(2'd3, 8'hFF);
    reg_read(2'd3, v); check("R9 addr3 reads zero", v, 8'h00);
    reg_read(2'd1, v); check("R9 addr3 write ignored dir", v, 8'h00);
    reg_read(2'd2, v); check("R9 addr3 write ignored ctrl", v, 8'h05);
    reg_write(2'd2, 8'h08);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    reg_write(2'd1, 8'h00);
    @(negedge clk);
    reg_addr = 2'd0; pin_in = 8'h3C;
    @(negedge clk); #1;
    check("R11 not after first edge", reg_rdata, 8'h00);
    @(negedge clk); #1;
    check("R11 port read after second edge", reg_rdata, 8'h3C);
    pin_in = 8'hC5;
    @(negedge clk); @(negedge clk); #1;
    check("R11 rx routing", {6'd0, sci1_rx, sci0_rx}, 8'h03);
    check("R11 spi routing", {4'd0, spi_in}, 8'h0C);
    reg_write(2'd0, 8'h0A);
    reg_write(2'd1, 8'h0F);
    reg_read(2'd0, v); check("R10 mixed port read", v, 8'hCA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gpio();
    t_serial();
    t_spi();
    t_ctrl();
    t_sync();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule